// File: doc/BRIEF.md
# MSI Snooping Cache Controller

This block keeps one direct-mapped, write-back cache coherent with its peers on a shared bus. Each line holds one of three states (Modified, Shared, Invalid), a tag equal to the full block address, and a block of two 32-bit words. A processor presents one request at a time. The controller serves reads and writes that hit without using the bus. On a miss it writes back a dirty victim if needed, then issues a read miss or a write miss. While it waits, it holds the processor with a busy flag.

The controller also watches every transaction that another cache wins on the bus. A miss from a peer that hits a Modified line makes this controller drive the block onto the bus and raise an abort so that memory does not answer. The same block value updates memory. A peer write miss removes any local copy. An external arbiter grants the bus one requester at a time. A granted transaction completes in its grant cycle: the fill data is present on `bus_rdata` during that cycle.

Top module: `msi_cache_ctrl`

## Requirements
- R1: After reset every line is Invalid, and `cpu_busy`, `bus_req` and `snp_abort` are low. The first access to any address therefore misses.
- R2: A processor read that misses requests the bus with command 1 (read miss) and the block address. On grant the line is filled from `bus_rdata` and becomes Shared. A read that hits in Shared or Modified causes no bus transaction.
- R3: A processor write to a line that is not Modified (Invalid, Shared, or holding another tag) requests the bus with command 2 (write miss). On grant the line becomes Modified, with the written word merged into the fetched block.
- R4: A miss whose victim line is Modified with a different tag first issues command 3 (write-back), carrying the victim tag and block, and only then issues the miss. A Shared victim is dropped without a write-back.
- R5: A snooped read miss (command 1) that matches a Modified line raises `snp_abort` and drives the block on `snp_data` in the same cycle, and the line becomes Shared. A later local write to that line then issues a write miss.
- R6: A snooped write miss (command 2) that matches a Modified line raises `snp_abort` and supplies the block, and the line becomes Invalid. A later local read then misses.
- R7: A snooped write miss that matches a Shared line makes it Invalid without raising `snp_abort`.
- R8: A snooped transaction whose address differs from the line tag, or that finds the line Invalid, or that is a write-back, leaves the line unchanged and does not abort.
- R9: Reads and writes that hit a Modified line cause no bus transaction.
- R10: `cpu_busy` is high from acceptance of a bus-needing request through the `cpu_done` cycle, and `cpu_done` is a single-cycle pulse. A bus request stays asserted with a stable command and address until granted.
- R11: `cpu_word` selects the word in the block: 0 is bits 31:0 and 1 is bits 63:32. A write changes only the selected word. For a read, `cpu_rdata` returns the selected word; for a write, it returns the written word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Processor request, held until `cpu_done` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Block address; its low bits pick the line |
| cpu_word | input | 1 | Word select in the block |
| cpu_wdata | input | WORD_W | Write data |
| cpu_busy | output | 1 | Processor must wait |
| cpu_done | output | 1 | Request completed this cycle |
| cpu_rdata | output | WORD_W | Read word, valid with `cpu_done` |
| bus_req | output | 1 | Bus request |
| bus_cmd | output | 2 | 0 none, 1 read miss, 2 write miss, 3 write-back |
| bus_addr | output | ADDR_W | Block address of the request |
| bus_wdata | output | 2*WORD_W | Block carried by a write-back |
| bus_gnt | input | 1 | Grant; the transaction completes this cycle |
| bus_rdata | input | 2*WORD_W | Fill block during a granted miss |
| snp_valid | input | 1 | A peer's transaction is on the bus |
| snp_cmd | input | 2 | Peer command, same encoding as `bus_cmd` |
| snp_addr | input | ADDR_W | Peer block address |
| snp_abort | output | 1 | This cache supplies the block; memory must not respond |
| snp_data | output | 2*WORD_W | Supplied block (zero when not aborting) |

## Verification
A wrong line state shows up at the ports only when that line is next touched. A line that should be Invalid but stays Shared lets a later read return stale data with no bus traffic. A line that should be Modified but is not produces an extra write miss where none belongs. A lost Modified state leaves a peer's miss without `snp_abort`, so the peer reads memory's stale copy, and the error appears in the returned word during that same transaction. The bench therefore pairs every observation of returned data with counts of bus commands and aborts between requests, and it runs several controllers against a flat model of memory, so that any state divergence surfaces within one or two later accesses to the same block.

// File: rtl/msi_pkg.sv
`timescale 1ns/1ps
// Shared types for the coherence controller: line states, bus commands and
// controller sequencing states. The bus command encoding is visible at ports.
package msi_pkg;

    typedef enum logic [1:0] {
        LS_INV = 2'd0,
        LS_SHR = 2'd1,
        LS_MOD = 2'd2
    } line_st_e;

    typedef enum logic [1:0] {
        BC_NONE   = 2'd0,
        BC_RDMISS = 2'd1,
        BC_WRMISS = 2'd2,
        BC_WBACK  = 2'd3
    } bus_cmd_e;

    typedef enum logic [1:0] {
        CS_IDLE  = 2'd0,
        CS_WBACK = 2'd1,
        CS_FETCH = 2'd2,
        CS_RESP  = 2'd3
    } ctl_st_e;

endpackage

// File: rtl/msi_line_store.sv
`timescale 1ns/1ps
// Per-line state, tag and block storage for a direct-mapped cache.
// Two asynchronous read ports (processor side, snoop side) and two write
// ports. Write port A (fills and hit writes) wins over port B (snoop state
// changes) on the same line; the controller never drives both on one line.
// Assumes NUM_LINES is a power of two, at least 2.
module msi_line_store
    import msi_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int NUM_LINES = 4,
    parameter int BLK_W     = 64
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [$clog2(NUM_LINES)-1:0] rd_a_idx,
    output line_st_e                     rd_a_state,
    output logic [ADDR_W-1:0]            rd_a_tag,
    output logic [BLK_W-1:0]             rd_a_data,
    input  logic [$clog2(NUM_LINES)-1:0] rd_b_idx,
    output line_st_e                     rd_b_state,
    output logic [ADDR_W-1:0]            rd_b_tag,
    output logic [BLK_W-1:0]             rd_b_data,
    input  logic                         wr_a_en,
    input  logic [$clog2(NUM_LINES)-1:0] wr_a_idx,
    input  line_st_e                     wr_a_state,
    input  logic [ADDR_W-1:0]            wr_a_tag,
    input  logic [BLK_W-1:0]             wr_a_data,
    input  logic                         wr_b_en,
    input  logic [$clog2(NUM_LINES)-1:0] wr_b_idx,
    input  line_st_e                     wr_b_state
);
    localparam int IDX_W = $clog2(NUM_LINES);

    line_st_e          st_arr  [NUM_LINES];
    logic [ADDR_W-1:0] tag_arr [NUM_LINES];
    logic [BLK_W-1:0]  dat_arr [NUM_LINES];

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        line_st_e          st_q;
        logic [ADDR_W-1:0] tag_q;
        logic [BLK_W-1:0]  dat_q;

        // Update one line from the fill port or the snoop port.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_q  <= LS_INV;
                tag_q <= '0;
                dat_q <= '0;
            end else if (wr_a_en && (wr_a_idx == IDX_W'(g))) begin
                st_q  <= wr_a_state;
                tag_q <= wr_a_tag;
                dat_q <= wr_a_data;
            end else if (wr_b_en && (wr_b_idx == IDX_W'(g))) begin
                st_q  <= wr_b_state;
            end
        end

        assign st_arr[g]  = st_q;
        assign tag_arr[g] = tag_q;
        assign dat_arr[g] = dat_q;
    end

    assign rd_a_state = st_arr[rd_a_idx];
    assign rd_a_tag   = tag_arr[rd_a_idx];
    assign rd_a_data  = dat_arr[rd_a_idx];
    assign rd_b_state = st_arr[rd_b_idx];
    assign rd_b_tag   = tag_arr[rd_b_idx];
    assign rd_b_data  = dat_arr[rd_b_idx];

endmodule

// File: rtl/msi_snoop_unit.sv
`timescale 1ns/1ps
// Decides the reaction to a peer's bus transaction on the addressed line.
// Purely combinational: match, new state, and whether to supply the block
// and abort memory. Write-backs and idle cycles never match.
module msi_snoop_unit
    import msi_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              snp_valid,
    input  logic [1:0]        snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    input  line_st_e          ln_state,
    input  logic [ADDR_W-1:0] ln_tag,
    output logic              upd,
    output line_st_e          next_state,
    output logic              abort
);
    logic is_miss;
    logic match;

    // Classify the peer command and compute the line's reaction.
    always_comb begin
        is_miss    = (snp_cmd == BC_RDMISS) || (snp_cmd == BC_WRMISS);
        match      = snp_valid && is_miss && (ln_state != LS_INV) && (ln_tag == snp_addr);
        abort      = match && (ln_state == LS_MOD);
        upd        = 1'b0;
        next_state = ln_state;
        if (match && (snp_cmd == BC_WRMISS)) begin
            upd        = 1'b1;
            next_state = LS_INV;
        end else if (match && (ln_state == LS_MOD)) begin
            upd        = 1'b1;
            next_state = LS_SHR;
        end
    end

endmodule

// File: rtl/msi_cache_ctrl.sv
`timescale 1ns/1ps
// Coherence controller for one direct-mapped write-back cache on a shared
// bus. Serves one processor request at a time: hits complete without the
// bus; misses optionally write back a dirty victim and then issue a read or
// write miss. Peer transactions are snooped every cycle.
// Assumes: a granted transaction completes in its grant cycle with fill data
// on bus_rdata; snp_valid is never high while this cache is granted; the
// processor holds its request fields until cpu_done.
module msi_cache_ctrl
    import msi_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int NUM_LINES = 4,
    parameter int WORD_W    = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cpu_req,
    input  logic                  cpu_we,
    input  logic [ADDR_W-1:0]     cpu_addr,
    input  logic                  cpu_word,
    input  logic [WORD_W-1:0]     cpu_wdata,
    output logic                  cpu_busy,
    output logic                  cpu_done,
    output logic [WORD_W-1:0]     cpu_rdata,
    output logic                  bus_req,
    output logic [1:0]            bus_cmd,
    output logic [ADDR_W-1:0]     bus_addr,
    output logic [2*WORD_W-1:0]   bus_wdata,
    input  logic                  bus_gnt,
    input  logic [2*WORD_W-1:0]   bus_rdata,
    input  logic                  snp_valid,
    input  logic [1:0]            snp_cmd,
    input  logic [ADDR_W-1:0]     snp_addr,
    output logic                  snp_abort,
    output logic [2*WORD_W-1:0]   snp_data
);
    localparam int IDX_W = $clog2(NUM_LINES);
    localparam int BLK_W = 2 * WORD_W;

    ctl_st_e           ctl_q, ctl_d;
    logic              req_we_q, req_word_q;
    logic [ADDR_W-1:0] req_addr_q;
    logic [WORD_W-1:0] req_wdata_q, rdata_q, rdata_d;

    logic [IDX_W-1:0]  a_idx, b_idx;
    line_st_e          a_state, b_state, upd_state, snp_next;
    logic [ADDR_W-1:0] a_tag, b_tag, upd_tag;
    logic [BLK_W-1:0]  a_data, b_data, upd_data, hit_merge, fill_merge;
    logic              upd_en, snp_upd, snp_hit_abort;
    logic              collide, accept, a_hit, hit_ok;
    bus_cmd_e          cmd_d;

    // Processor-side line index: live request in idle, latched one otherwise.
    assign a_idx   = (ctl_q == CS_IDLE) ? cpu_addr[IDX_W-1:0] : req_addr_q[IDX_W-1:0];
    assign b_idx   = snp_addr[IDX_W-1:0];
    assign collide = cpu_req && snp_valid && (b_idx == cpu_addr[IDX_W-1:0]);
    assign accept  = (ctl_q == CS_IDLE) && cpu_req && !collide;
    assign a_hit   = (a_state != LS_INV) && (a_tag == cpu_addr);
    assign hit_ok  = cpu_we ? (a_hit && (a_state == LS_MOD)) : a_hit;

    msi_line_store #(
        .ADDR_W   (ADDR_W),
        .NUM_LINES(NUM_LINES),
        .BLK_W    (BLK_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_a_idx  (a_idx),
        .rd_a_state(a_state),
        .rd_a_tag  (a_tag),
        .rd_a_data (a_data),
        .rd_b_idx  (b_idx),
        .rd_b_state(b_state),
        .rd_b_tag  (b_tag),
        .rd_b_data (b_data),
        .wr_a_en   (upd_en),
        .wr_a_idx  (a_idx),
        .wr_a_state(upd_state),
        .wr_a_tag  (upd_tag),
        .wr_a_data (upd_data),
        .wr_b_en   (snp_upd),
        .wr_b_idx  (b_idx),
        .wr_b_state(snp_next)
    );

    msi_snoop_unit #(
        .ADDR_W(ADDR_W)
    ) u_snoop (
        .snp_valid (snp_valid),
        .snp_cmd   (snp_cmd),
        .snp_addr  (snp_addr),
        .ln_state  (b_state),
        .ln_tag    (b_tag),
        .upd       (snp_upd),
        .next_state(snp_next),
        .abort     (snp_hit_abort)
    );

    assign snp_abort = snp_hit_abort;
    assign snp_data  = snp_hit_abort ? b_data : '0;

    // Merge a write word into the cached block (hit) or the fetched block (fill).
    always_comb begin
        hit_merge  = a_data;
        fill_merge = bus_rdata;
        if (cpu_word) hit_merge[BLK_W-1:WORD_W] = cpu_wdata;
        else          hit_merge[WORD_W-1:0]     = cpu_wdata;
        if (req_word_q) fill_merge[BLK_W-1:WORD_W] = req_wdata_q;
        else            fill_merge[WORD_W-1:0]     = req_wdata_q;
    end

    // Sequencing: hit service, victim write-back, miss fetch, response.
    always_comb begin
        ctl_d     = ctl_q;
        upd_en    = 1'b0;
        upd_state = a_state;
        upd_tag   = a_tag;
        upd_data  = a_data;
        rdata_d   = rdata_q;
        bus_req   = 1'b0;
        cmd_d     = BC_NONE;
        bus_addr  = '0;
        bus_wdata = '0;
        case (ctl_q)
            CS_IDLE: begin
                if (accept) begin
                    if (hit_ok) begin
                        ctl_d = CS_RESP;
                        if (cpu_we) begin
                            upd_en   = 1'b1;
                            upd_data = hit_merge;
                            rdata_d  = cpu_wdata;
                        end else begin
                            rdata_d  = cpu_word ? a_data[BLK_W-1:WORD_W] : a_data[WORD_W-1:0];
                        end
                    end else if (a_state == LS_MOD) begin
                        ctl_d = CS_WBACK;
                    end else begin
                        ctl_d = CS_FETCH;
                    end
                end
            end
            CS_WBACK: begin
                if (a_state != LS_MOD) begin
                    ctl_d = CS_FETCH;
                end else begin
                    bus_req   = 1'b1;
                    cmd_d     = BC_WBACK;
                    bus_addr  = a_tag;
                    bus_wdata = a_data;
                    if (bus_gnt) ctl_d = CS_FETCH;
                end
            end
            CS_FETCH: begin
                bus_req  = 1'b1;
                cmd_d    = req_we_q ? BC_WRMISS : BC_RDMISS;
                bus_addr = req_addr_q;
                if (bus_gnt) begin
                    ctl_d   = CS_RESP;
                    upd_en  = 1'b1;
                    upd_tag = req_addr_q;
                    if (req_we_q) begin
                        upd_state = LS_MOD;
                        upd_data  = fill_merge;
                        rdata_d   = req_wdata_q;
                    end else begin
                        upd_state = LS_SHR;
                        upd_data  = bus_rdata;
                        rdata_d   = req_word_q ? bus_rdata[BLK_W-1:WORD_W] : bus_rdata[WORD_W-1:0];
                    end
                end
            end
            default: ctl_d = CS_IDLE;
        endcase
    end

    assign bus_cmd = cmd_d;

    // Controller state, latched request and response word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q       <= CS_IDLE;
            req_we_q    <= 1'b0;
            req_word_q  <= 1'b0;
            req_addr_q  <= '0;
            req_wdata_q <= '0;
            rdata_q     <= '0;
        end else begin
            ctl_q   <= ctl_d;
            rdata_q <= rdata_d;
            if (accept) begin
                req_we_q    <= cpu_we;
                req_word_q  <= cpu_word;
                req_addr_q  <= cpu_addr;
                req_wdata_q <= cpu_wdata;
            end
        end
    end

    assign cpu_busy  = (ctl_q != CS_IDLE) || collide;
    assign cpu_done  = (ctl_q == CS_RESP);
    assign cpu_rdata = rdata_q;

endmodule

// File: rtl/msi_cache_ctrl_chk.sv
`timescale 1ns/1ps
// Port-level protocol checks for msi_cache_ctrl, attached with bind.
module msi_cache_ctrl_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_busy,
    input logic              cpu_done,
    input logic              bus_req,
    input logic [1:0]        bus_cmd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_gnt,
    input logic              snp_valid,
    input logic [1:0]        snp_cmd,
    input logic              snp_abort
);
    // R5, R8: abort only answers a peer read or write miss
    a_r5_abort_on_peer_miss: assert property (@(posedge clk) disable iff (!rst_n)
        snp_abort |-> (snp_valid && ((snp_cmd == 2'd1) || (snp_cmd == 2'd2))));

    // R10: bus traffic only while the processor is stalled
    a_r10_bus_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> cpu_busy);

    // R10: completion is a single-cycle pulse
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |=> !cpu_done);

    // R4: a granted write-back is followed by the miss itself
    a_r4_miss_after_wback: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_gnt && (bus_cmd == 2'd3)) |=> (bus_req && (bus_cmd != 2'd3) && (bus_cmd != 2'd0)));

    // R10: an ungranted miss request holds command and address
    a_r10_miss_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_gnt && (bus_cmd != 2'd3)) |=> (bus_req && $stable(bus_cmd) && $stable(bus_addr)));

    // R2: a request always carries a real command
    a_r2_req_has_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> (bus_cmd != 2'd0));

endmodule

bind msi_cache_ctrl msi_cache_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpu_busy (cpu_busy),
    .cpu_done (cpu_done),
    .bus_req  (bus_req),
    .bus_cmd  (bus_cmd),
    .bus_addr (bus_addr),
    .bus_gnt  (bus_gnt),
    .snp_valid(snp_valid),
    .snp_cmd  (snp_cmd),
    .snp_abort(snp_abort)
);

// File: tb/msi_cache_ctrl_tb.sv
`timescale 1ns/1ps
// Three controllers on one bus with a fixed-priority arbiter and a flat
// memory model. Directed coherence scenarios, then a long deterministic
// sweep checked against a golden word array.
module msi_cache_ctrl_tb;
    localparam int NC = 3;
    localparam int ADDR_W = 8;
    localparam int NUM_LINES = 4;
    localparam int WORD_W = 32;
    localparam int BLK_W = 64;
    localparam int NADDR = 1 << ADDR_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [NC-1:0]     cpu_req = '0, cpu_we = '0, cpu_word = '0;
    logic [NC-1:0]     cpu_busy, cpu_done;
    logic [ADDR_W-1:0] cpu_addr  [NC];
    logic [WORD_W-1:0] cpu_wdata [NC];
    logic [WORD_W-1:0] cpu_rdata [NC];
    logic [NC-1:0]     bus_req, bus_gnt, snp_valid, snp_abort;
    logic [1:0]        bus_cmd   [NC];
    logic [ADDR_W-1:0] bus_addr  [NC];
    logic [BLK_W-1:0]  bus_wdata [NC];
    logic [BLK_W-1:0]  snp_data  [NC];
    logic [BLK_W-1:0]  bus_rdata;
    logic [1:0]        snp_cmd;
    logic [ADDR_W-1:0] snp_addr;
    logic              gnt_any;
    int                m_idx;
    logic              gnt_block = 1'b0;
    logic              mem_init = 1'b0;
    logic [BLK_W-1:0]  mem [NADDR];
    logic [WORD_W-1:0] gold [NADDR][2];

    int checks = 0, fails = 0;
    int n_rd = 0, n_wr = 0, n_wb = 0, n_ab = 0;
    int s_rd, s_wr, s_wb, s_ab;
    logic [ADDR_W-1:0] last_wb_addr = '0;

    for (genvar g = 0; g < NC; g++) begin : g_node
        msi_cache_ctrl #(
            .ADDR_W(ADDR_W), .NUM_LINES(NUM_LINES), .WORD_W(WORD_W)
        ) u_dut (
            .clk(clk), .rst_n(rst_n),
            .cpu_req(cpu_req[g]), .cpu_we(cpu_we[g]), .cpu_addr(cpu_addr[g]),
            .cpu_word(cpu_word[g]), .cpu_wdata(cpu_wdata[g]),
            .cpu_busy(cpu_busy[g]), .cpu_done(cpu_done[g]), .cpu_rdata(cpu_rdata[g]),
            .bus_req(bus_req[g]), .bus_cmd(bus_cmd[g]), .bus_addr(bus_addr[g]),
            .bus_wdata(bus_wdata[g]), .bus_gnt(bus_gnt[g]), .bus_rdata(bus_rdata),
            .snp_valid(snp_valid[g]), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
            .snp_abort(snp_abort[g]), .snp_data(snp_data[g])
        );
    end

    function automatic logic [WORD_W-1:0] init_word(int a, int w);
        return 32'h5A00_0000 + WORD_W'(a * 16 + w);
    endfunction

    // Fixed-priority arbiter and snoop broadcast.
    always_comb begin
        bus_gnt = '0;
        gnt_any = 1'b0;
        m_idx   = 0;
        if (!gnt_block) begin
            for (int i = 0; i < NC; i++) begin
                if (bus_req[i] && !gnt_any) begin
                    bus_gnt[i] = 1'b1;
                    gnt_any    = 1'b1;
                    m_idx      = i;
                end
            end
        end
        snp_cmd   = gnt_any ? bus_cmd[m_idx] : 2'd0;
        snp_addr  = gnt_any ? bus_addr[m_idx] : '0;
        snp_valid = gnt_any ? ~bus_gnt : '0;
    end

    // Fill data: a supplying cache overrides memory.
    always_comb begin
        bus_rdata = mem[snp_addr];
        for (int i = 0; i < NC; i++)
            if (snp_abort[i]) bus_rdata = snp_data[i];
    end

    // Memory model updates from write-backs and supplied blocks.
    always @(posedge clk) begin
        if (mem_init) begin
            for (int a = 0; a < NADDR; a++) mem[a] <= {init_word(a, 1), init_word(a, 0)};
        end else begin
            if (gnt_any && (snp_cmd == 2'd3)) mem[snp_addr] <= bus_wdata[m_idx];
            for (int i = 0; i < NC; i++)
                if (snp_abort[i]) mem[snp_addr] <= snp_data[i];
        end
    end

    // Bus event counters.
    always @(posedge clk) begin
        for (int i = 0; i < NC; i++) begin
            if (bus_gnt[i]) begin
                case (bus_cmd[i])
                    2'd1: n_rd++;
                    2'd2: n_wr++;
                    2'd3: begin n_wb++; last_wb_addr = bus_addr[i]; end
                    default: ;
                endcase
            end
        end
        if (|snp_abort) n_ab++;
    end

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic snap();
        s_rd = n_rd; s_wr = n_wr; s_wb = n_wb; s_ab = n_ab;
    endtask

    function automatic int traffic();
        return (n_rd - s_rd) + (n_wr - s_wr) + (n_wb - s_wb);
    endfunction

    task automatic do_op(input int p, input bit we, input int a, input bit w,
                         input logic [WORD_W-1:0] d, output logic [WORD_W-1:0] rd);
        int cyc;
        @(negedge clk);
        cpu_req[p]   = 1'b1;
        cpu_we[p]    = we;
        cpu_addr[p]  = a[ADDR_W-1:0];
        cpu_word[p]  = w;
        cpu_wdata[p] = d;
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
        end while (!cpu_done[p] && cyc < 1000);
        if (cyc >= 1000) chk("R10 request completes", 64'(cyc), 64'd0);
        rd = cpu_rdata[p];
        cpu_req[p] = 1'b0;
        if (we) gold[a][w] = d;
    endtask

    task automatic reset_all();
        rst_n = 1'b0;
        mem_init = 1'b1;
        cpu_req = '0;
        gnt_block = 1'b0;
        for (int i = 0; i < NC; i++) begin
            cpu_addr[i] = '0; cpu_wdata[i] = '0;
        end
        for (int a = 0; a < NADDR; a++) begin
            gold[a][0] = init_word(a, 0);
            gold[a][1] = init_word(a, 1);
        end
        repeat (3) @(negedge clk);
        mem_init = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R10 actual=hung expected=finished");
        finish_run();
    end

    initial begin
        logic [WORD_W-1:0] rd;
        logic [31:0] lcg;
        int cyc;
        int alist [6] = '{8'h00, 8'h04, 8'h10, 8'h01, 8'h05, 8'h02};

        reset_all();
        // R1: reset state
        chk("R1 busy after reset", 64'(cpu_busy), 64'd0);
        chk("R1 bus_req after reset", 64'(bus_req), 64'd0);
        chk("R1 abort after reset", 64'(snp_abort), 64'd0);

        // R2: read miss then Shared hit
        snap(); do_op(0, 0, 8'h08, 0, 0, rd);
        chk("R2 read miss data", 64'(rd), 64'(init_word(8, 0)));
        chk("R2 read miss command", 64'(n_rd - s_rd), 64'd1);
        snap(); do_op(0, 0, 8'h08, 1, 0, rd);
        chk("R11 word1 select", 64'(rd), 64'(init_word(8, 1)));
        chk("R2 shared hit silent", 64'(traffic()), 64'd0);

        // R3: write on Shared is a write miss; R9 and R11 on Modified
        snap(); do_op(0, 1, 8'h08, 0, 32'h1111_0000, rd);
        chk("R3 write miss from shared", 64'(n_wr - s_wr), 64'd1);
        snap(); do_op(0, 1, 8'h08, 1, 32'h2222_0001, rd);
        chk("R9 write hit modified silent", 64'(traffic()), 64'd0);
        snap(); do_op(0, 0, 8'h08, 0, 0, rd);
        chk("R11 word0 kept", 64'(rd), 64'h1111_0000);
        chk("R9 read hit modified silent", 64'(traffic()), 64'd0);

        // R5: peer read miss on Modified
        snap(); do_op(1, 0, 8'h08, 0, 0, rd);
        chk("R5 supplied data", 64'(rd), 64'h1111_0000);
        chk("R5 abort raised", 64'(n_ab - s_ab), 64'd1);
        chk("R5 memory updated", mem[8], 64'h2222_0001_1111_0000);
        snap(); do_op(0, 0, 8'h08, 1, 0, rd);
        chk("R5 owner keeps shared copy", 64'(traffic()), 64'd0);
        snap(); do_op(0, 1, 8'h08, 0, 32'h3333_0000, rd);
        chk("R5 owner now shared write miss", 64'(n_wr - s_wr), 64'd1);
        chk("R7 no abort from shared", 64'(n_ab - s_ab), 64'd0);
        snap(); do_op(1, 0, 8'h08, 0, 0, rd);
        chk("R7 shared copy invalidated", 64'(n_rd - s_rd), 64'd1);
        chk("R7 fresh data", 64'(rd), 64'h3333_0000);

        // R6: peer write miss on Modified
        do_op(2, 1, 8'h08, 1, 32'h4444_0001, rd);
        snap(); do_op(1, 1, 8'h08, 0, 32'h5555_0000, rd);
        chk("R6 abort on write miss", 64'(n_ab - s_ab), 64'd1);
        snap(); do_op(2, 0, 8'h08, 1, 0, rd);
        chk("R6 owner invalidated", 64'(n_rd - s_rd), 64'd1);
        chk("R6 data carried", 64'(rd), 64'h4444_0001);

        // R4: dirty victim written back first, clean victim dropped
        do_op(0, 1, 8'h0C, 0, 32'h6666_0000, rd);
        snap(); do_op(0, 0, 8'h10, 1, 0, rd);
        chk("R4 write-back issued", 64'(n_wb - s_wb), 64'd1);
        chk("R4 write-back address", 64'(last_wb_addr), 64'h0C);
        chk("R4 memory holds victim", 64'(mem[8'h0C][31:0]), 64'h6666_0000);
        chk("R4 new line data", 64'(rd), 64'(init_word(16, 1)));
        snap(); do_op(0, 0, 8'h0C, 0, 0, rd);
        chk("R4 clean victim no write-back", 64'(n_wb - s_wb), 64'd0);
        chk("R4 reread victim", 64'(rd), 64'h6666_0000);

        // R8: tag mismatch leaves Modified line alone
        do_op(0, 1, 8'h01, 0, 32'h7777_0000, rd);
        snap(); do_op(1, 0, 8'h05, 0, 0, rd);
        chk("R8 no abort on tag mismatch", 64'(n_ab - s_ab), 64'd0);
        chk("R8 mismatch data from memory", 64'(rd), 64'(init_word(5, 0)));
        snap(); do_op(0, 1, 8'h01, 1, 32'h7777_0001, rd);
        chk("R8 line still modified", 64'(traffic()), 64'd0);

        // R10: stall while the bus is withheld
        gnt_block = 1'b1;
        @(negedge clk);
        cpu_req[1] = 1'b1; cpu_we[1] = 1'b0; cpu_addr[1] = 8'h30; cpu_word[1] = 1'b0;
        repeat (4) @(negedge clk);
        chk("R10 busy while waiting", 64'(cpu_busy[1]), 64'd1);
        chk("R10 request held", 64'(bus_req[1]), 64'd1);
        chk("R10 command held", 64'(bus_cmd[1]), 64'd1);
        chk("R10 no early done", 64'(cpu_done[1]), 64'd0);
        gnt_block = 1'b0;
        cyc = 0;
        do begin @(negedge clk); cyc++; end while (!cpu_done[1] && cyc < 100);
        chk("R10 data after stall", 64'(cpu_rdata[1]), 64'(init_word(48, 0)));
        cpu_req[1] = 1'b0;
        @(negedge clk);
        chk("R10 busy released", 64'(cpu_busy[1]), 64'd0);

        // Sweep: mixed operations on conflicting addresses against golden words
        reset_all();
        lcg = 32'h1234_5678;
        for (int step = 0; step < 900; step++) begin
            int p, a;
            bit we, w;
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            p  = int'(lcg[25:16]) % NC;
            we = lcg[27];
            a  = alist[int'(lcg[13:6]) % 6];
            w  = lcg[29];
            if (we) begin
                do_op(p, 1, a, w, lcg ^ 32'hC0DE_0000, rd);
            end else begin
                do_op(p, 0, a, w, 0, rd);
                chk("R5 R6 R7 sweep coherent read", 64'(rd), 64'(gold[a][w]));
            end
        end

        finish_run();
    end

endmodule